// File: doc/BRIEF.md
# Software-Triggered SCI Event Register

This block is a 16-bit control register on a simple register bus. Software uses it to raise a system control interrupt (SCI) event, or leaves the SCI path disabled so that events go through a separate SMI trigger register. The register holds three things:

- an event-source select bit;
- fourteen scratch bits that hardware only stores;
- a trigger bit.

When the select bit chooses SCI and a write moves the trigger bit from 0 to 1, the block emits a one-cycle SCI message. That message sets a sticky status bit, so downstream logic sees a level. The status bit is cleared through its own write-one-to-clear input.

Hardware never clears the trigger bit. Software writes 0 to re-arm it, and only the next 0-to-1 write fires again. Writes are byte-enabled. The trigger is judged by comparing the stored bit 0 with the value the write leaves in it. The select bit used in that judgement is the one the same write leaves in the register.

Top module: `sci_soft_trigger`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, rd_data is 0x0000, sci_msg is 0 and sci_status is 0. Reset never produces a message.
- R2: Bit 15 is the event-source select (0 = SMI, 1 = SCI). It is written by lane 1 (wr_be[1]) and reads back on rd_data[15].
- R3: Bits 14:1 are scratch bits. They store whatever is written in enabled lanes and read back unchanged. They never cause or block a message.
- R4: Bit 0 is the trigger bit. It is written by lane 0 (wr_be[0]). Hardware never changes it, so the whole register keeps its value on every cycle without a write.
- R5: A write with wr_be[0]=1 that takes bit 0 from 0 to 1, and leaves bit 15 at 1 after the write, produces exactly one sci_msg pulse. The pulse is high during the cycle after the clock edge that accepts the write.
- R6: A write whose effect on bit 0 is 1→0, 0→0 or 1→1 produces no message.
- R7: While bit 15 is 0 after the write, no write to bit 0 produces a message.
- R8: Lane 0 (wr_be[0]) covers bits 7:0 and lane 1 (wr_be[1]) covers bits 15:8. A disabled lane leaves its bits unchanged. A write without wr_be[0] cannot trigger.
- R9: sci_status becomes 1 on the clock edge that ends a sci_msg cycle. It then stays at 1 until it is cleared.
- R10: status_clr=1 clears sci_status on the next edge. When sci_msg and status_clr are high in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe, accepted on the rising edge |
| wr_be | input | 2 | Byte-lane enables: bit 0 covers data 7:0, bit 1 covers data 15:8 |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register contents |
| status_clr | input | 1 | Write-one-to-clear for the sticky status bit |
| sci_msg | output | 1 | One-cycle SCI message pulse |
| sci_status | output | 1 | Sticky SCI event status level |

## Verification
The trigger bit is driven through all four write transitions, both with the select bit at SCI and with it at SMI. This separates a true edge detector from a level detector, and from a detector that ignores the select bit. Writes that enable only one lane show whether byte enables gate both the stored value and the trigger. A single write that sets the select bit and the trigger bit together checks that the post-write select value qualifies the edge. Scratch patterns 0xAAAA and 0xD554 expose stuck or swapped bits. A clear pulse placed in the same cycle as a message tests set-over-clear priority.

// File: rtl/sci_trig_pkg.sv
package sci_trig_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned LANE_W   = 8;
  localparam int unsigned LANES    = REG_W / LANE_W;
  localparam int unsigned SEL_BIT  = REG_W - 1;
  localparam int unsigned TRIG_BIT = 0;
  localparam int unsigned TRIG_LANE = TRIG_BIT / LANE_W;

  typedef logic [REG_W-1:0] reg_word_t;
  typedef logic [LANES-1:0] lane_mask_t;
endpackage

// File: rtl/sci_trig_regfile.sv
module sci_trig_regfile
  import sci_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  lane_mask_t wr_be,
  input  reg_word_t  wr_data,
  output reg_word_t  ctrl_q,
  output reg_word_t  ctrl_d
);

  reg_word_t next_word;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      always_comb begin
        if (wr_en && wr_be[g]) begin
          next_word[g*LANE_W +: LANE_W] = wr_data[g*LANE_W +: LANE_W];
        end else begin
          next_word[g*LANE_W +: LANE_W] = ctrl_q[g*LANE_W +: LANE_W];
        end
      end
    end
  endgenerate

  assign ctrl_d = next_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= next_word;
    end
  end

  // R4: the register holds its value on every cycle without a write
  p_hold_without_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));

  // R8: a write with lane 0 disabled leaves the trigger bit alone
  p_lane_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_be[TRIG_LANE]) |=> $stable(ctrl_q[TRIG_BIT]));

endmodule

// File: rtl/sci_trig_edge.sv
module sci_trig_edge
  import sci_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  lane_mask_t wr_be,
  input  reg_word_t  ctrl_q,
  input  reg_word_t  ctrl_d,
  output logic       msg_q
);

  logic rise_qual;
  logic msg_d;

  always_comb begin
    rise_qual = wr_en && wr_be[TRIG_LANE] && !ctrl_q[TRIG_BIT] && ctrl_d[TRIG_BIT];
    msg_d     = rise_qual && ctrl_d[SEL_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_q <= 1'b0;
    end else begin
      msg_q <= msg_d;
    end
  end

  // R5: a message lasts exactly one cycle
  p_msg_single_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_q |=> !msg_q);

  // R7: a message always sees the register selecting SCI with the trigger set
  p_msg_needs_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_q |-> (ctrl_q[SEL_BIT] && ctrl_q[TRIG_BIT]));

endmodule

// File: rtl/sci_trig_status.sv
module sci_trig_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic status_q
);

  logic status_d;

  always_comb begin
    status_d = status_q;
    if (clr_i) status_d = 1'b0;
    if (set_i) status_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
    end else begin
      status_q <= status_d;
    end
  end

  // R9 / R10: a message sets the status, even against a clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> status_q);

  // R9: status stays set without a clear
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !clr_i) |=> status_q);

endmodule

// File: rtl/sci_soft_trigger.sv
module sci_soft_trigger
  import sci_trig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANES-1:0]  wr_be,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              status_clr,
  output logic              sci_msg,
  output logic              sci_status
);

  reg_word_t ctrl_q;
  reg_word_t ctrl_d;
  logic      msg_q;

  sci_trig_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_be   (wr_be),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q),
    .ctrl_d  (ctrl_d)
  );

  sci_trig_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_be  (wr_be),
    .ctrl_q (ctrl_q),
    .ctrl_d (ctrl_d),
    .msg_q  (msg_q)
  );

  sci_trig_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (msg_q),
    .clr_i    (status_clr),
    .status_q (sci_status)
  );

  assign rd_data = ctrl_q;
  assign sci_msg = msg_q;

  // R6: a write that leaves bit 0 at 0 is never followed by a message
  p_no_msg_on_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ctrl_d[TRIG_BIT]) |=> !sci_msg);

endmodule

// File: tb/sci_soft_trigger_test.sv
module sci_soft_trigger_test;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_be;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        status_clr;
  logic        sci_msg;
  logic        sci_status;

  int checks;
  int failures;

  logic [15:0] m_reg;
  logic        m_msg;
  logic        m_status;

  sci_soft_trigger uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .status_clr(status_clr), .sci_msg(sci_msg), .sci_status(sci_status)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin : model
    logic [15:0] nv;
    if (!rst_n) begin
      m_reg <= 16'h0; m_msg <= 1'b0; m_status <= 1'b0;
    end else begin
      nv = m_reg;
      if (wr_en && wr_be[0]) nv[7:0]  = wr_data[7:0];
      if (wr_en && wr_be[1]) nv[15:8] = wr_data[15:8];
      m_msg    <= wr_en && wr_be[0] && (m_reg[0] == 1'b0) && nv[0] && nv[15];
      m_status <= m_msg ? 1'b1 : (status_clr ? 1'b0 : m_status);
      m_reg    <= nv;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    chk(rd_data == m_reg, "R4 rd_data vs model", rd_data, m_reg);
    chk(sci_msg == m_msg, "R5 sci_msg vs model", {15'b0, sci_msg}, {15'b0, m_msg});
    chk(sci_status == m_status, "R9 sci_status vs model", {15'b0, sci_status}, {15'b0, m_status});
  end

  task automatic wr(input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 2'b00; wr_data = 16'h0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_be = 2'b00; wr_data = 16'h0; status_clr = 1'b0;
    idle(3);
    #1 chk(rd_data == 16'h0 && !sci_msg && !sci_status, "R1 during reset", rd_data, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 16'h0 && !sci_msg && !sci_status, "R1 after release", rd_data, 16'h0);

    wr(2'b11, 16'h0001);   // select SMI, bit0 0->1
    chk(!sci_msg, "R7 no msg with SMI selected", {15'b0, sci_msg}, 16'h0);
    chk(rd_data == 16'h0001, "R4 trigger stored", rd_data, 16'h0001);
    wr(2'b11, 16'h0000);
    wr(2'b11, 16'h8000);   // select SCI, bit0 0->0
    chk(!sci_msg, "R6 0->0 no msg", {15'b0, sci_msg}, 16'h0);
    chk(rd_data[15], "R2 select reads back", rd_data, 16'h8000);
    wr(2'b11, 16'h8001);   // 0->1 with SCI
    chk(sci_msg, "R5 message pulse", {15'b0, sci_msg}, 16'h1);
    @(negedge clk);
    chk(!sci_msg, "R5 pulse is one cycle", {15'b0, sci_msg}, 16'h0);
    chk(sci_status, "R9 status set", {15'b0, sci_status}, 16'h1);
    wr(2'b11, 16'h8001);   // 1->1
    chk(!sci_msg, "R6 1->1 no msg", {15'b0, sci_msg}, 16'h0);
    idle(5);
    chk(rd_data == 16'h8001, "R4 not self-cleared", rd_data, 16'h8001);
    chk(sci_status, "R9 status sticky", {15'b0, sci_status}, 16'h1);
    wr(2'b01, 16'h0000);   // 1->0
    chk(!sci_msg && rd_data == 16'h8000, "R6 1->0 no msg", rd_data, 16'h8000);
    wr(2'b10, 16'h80FF);   // lane 0 disabled
    chk(!sci_msg && rd_data == 16'h8000, "R8 lane0 off cannot trigger", rd_data, 16'h8000);
    wr(2'b11, 16'hAAAA);
    chk(rd_data == 16'hAAAA && !sci_msg, "R3 scratch pattern A", rd_data, 16'hAAAA);
    wr(2'b11, 16'hD554);
    chk(rd_data == 16'hD554 && !sci_msg, "R3 scratch pattern B", rd_data, 16'hD554);
    wr(2'b01, 16'h00FF);   // lane 0 only, 0->1 with SCI kept in high byte
    chk(rd_data == 16'hD5FF && sci_msg, "R8 lane0 write triggers", rd_data, 16'hD5FF);
    @(negedge clk); status_clr = 1'b1;
    @(negedge clk); status_clr = 1'b0;
    chk(!sci_status, "R10 clear", {15'b0, sci_status}, 16'h0);
    wr(2'b11, 16'h0000);
    wr(2'b01, 16'h8001);   // select lane off: stays SMI
    chk(!sci_msg && rd_data == 16'h0001, "R7 lane1 off keeps SMI", rd_data, 16'h0001);
    wr(2'b11, 16'h0000);
    wr(2'b11, 16'h8001);   // select and trigger in one write
    chk(sci_msg, "R5 combined select+trigger", {15'b0, sci_msg}, 16'h1);
    status_clr = 1'b1;     // same cycle as message
    @(negedge clk); status_clr = 1'b0;
    chk(sci_status, "R10 set wins over clear", {15'b0, sci_status}, 16'h1);
    @(negedge clk); rst_n = 1'b0;
    #1 chk(rd_data == 16'h0 && !sci_status, "R1 mid-run reset", rd_data, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule